// File: doc/BRIEF.md
# Translation Lookaside Buffer with Page Invalidation and Root-Switch Flush

This block holds a small, fully associative set of recent translations from virtual page to physical frame. It sits in front of a page-table walker. A lookup compares the virtual page number against every stored tag in parallel. On a hit, the physical address and the permission bits appear combinationally in the same cycle. On a miss, with the lookup qualified, the block raises a request so that the walker starts a walk. When the walk finishes, the walker writes the result back through the fill port.

Two maintenance operations keep the cached state consistent with the tables in memory. The first drops one page by virtual address, for use after a mapping is removed. The second clears every entry not marked global, for use when the root table pointer changes. If a fill arrives in the same cycle as either maintenance operation, the fill is applied first and the maintenance operation second. Because of this ordering, a translation that was just written can never outlive an invalidation issued in the same cycle.

Top module: `tlb_cache`

## Requirements
- R1: After synchronous reset, every entry is invalid, so any qualified lookup misses and raises `walk_req`.
- R2: When a lookup matches a valid entry, in the same cycle `lk_hit` is 1, `walk_req` is 0, `lk_pa` equals the stored 36-bit frame concatenated above `lk_va[11:0]`, and `lk_wr`, `lk_usr` and `lk_nx` carry the stored flags.
- R3: A qualified lookup (`lk_valid`=1) that matches no valid entry gives `lk_hit`=0 and `walk_req`=1.
- R4: After a fill, a lookup of that page hits. A fill whose tag is already stored overwrites that entry in place, with the new frame and flags, and never creates a second copy.
- R5: A fill of a new tag takes the lowest-numbered invalid slot if one exists. When all 16 slots are valid, it replaces the slot named by a round-robin pointer. The pointer starts at 0 and advances by one only on such replacements.
- R6: A single-page invalidate removes the entry whose tag matches `inv_va[47:12]`, and leaves every other entry untouched.
- R7: A root-switch pulse (`root_sw`) invalidates every entry that was filled with `fill_glb`=0, and keeps entries filled with `fill_glb`=1.
- R8: When a fill and an invalidate or root-switch flush occur in the same cycle, the fill is applied first. A fill of the invalidated page, or a non-global fill during a flush, is therefore gone afterwards. A global fill during a flush survives.
- R9: The tag is bits 47:12 of the virtual address. Addresses that differ only in bits 11:0 refer to the same entry, for lookup and for invalidation alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup qualifier; gates `walk_req` |
| lk_va | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | A valid entry matches `lk_va` |
| walk_req | output | 1 | Qualified lookup missed; a walk is needed |
| lk_pa | output | 48 | Translated physical address |
| lk_wr | output | 1 | Stored writable flag |
| lk_usr | output | 1 | Stored user-access flag |
| lk_nx | output | 1 | Stored no-execute flag |
| fill_en | input | 1 | Write a translation returned by the walker |
| fill_va | input | 48 | Virtual address of the fill |
| fill_pfn | input | 36 | Physical frame number of the fill |
| fill_wr | input | 1 | Writable flag of the fill |
| fill_usr | input | 1 | User-access flag of the fill |
| fill_nx | input | 1 | No-execute flag of the fill |
| fill_glb | input | 1 | Global flag of the fill |
| inv_en | input | 1 | Invalidate one page |
| inv_va | input | 48 | Virtual address to invalidate |
| root_sw | input | 1 | Root table switch; flush non-global entries |

## Verification
The hardest situation to reach is eviction by the round-robin pointer, because it requires all 16 slots to be valid and holding known tags. The stimulus fills 16 distinct pages, including one refill of an already stored tag. It then reads all of them back, which shows that the refill did not take a slot of its own. After that, it forces two pointer replacements. An invalidate then opens a hole, and the next fill must take that hole while the pointer stays where it was. The same-cycle fill and maintenance cases are driven as single cycles, and each is followed by lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 48;
  localparam int PG_W  = 12;
  localparam int TAG_W = VA_W - PG_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] pfn;
    logic             wr;
    logic             usr;
    logic             nx;
    logic             glb;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N  = 16,
  parameter int TW = 36
) (
  input  logic [N-1:0][TW-1:0] tags,
  input  logic [N-1:0]         vld,
  input  logic [TW-1:0]        key,
  output logic [N-1:0]         hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  same_tag,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] idx,
  output logic          use_ptr
);
  always_comb begin
    idx     = ptr;
    use_ptr = 1'b1;
    if (|same_tag) begin
      use_ptr = 1'b0;
      for (int i = N - 1; i >= 0; i--)
        if (same_tag[i]) idx = IW'(i);
    end else if (!(&vld)) begin
      use_ptr = 1'b0;
      for (int i = N - 1; i >= 0; i--)
        if (!vld[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic             walk_req,
  output logic [VA_W-1:0]  lk_pa,
  output logic             lk_wr,
  output logic             lk_usr,
  output logic             lk_nx,
  input  logic             fill_en,
  input  logic [VA_W-1:0]  fill_va,
  input  logic [TAG_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_usr,
  input  logic             fill_nx,
  input  logic             fill_glb,
  input  logic             inv_en,
  input  logic [VA_W-1:0]  inv_va,
  input  logic             root_sw
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_ent_t                     ent_q [ENTRIES];
  logic [ENTRIES-1:0]           vld_q, vld_n;
  logic [IW-1:0]                ptr_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_v;
  logic [ENTRIES-1:0]           glb_v;
  logic [ENTRIES-1:0]           lk_match, fill_match, inv_match;
  logic [IW-1:0]                fidx;
  logic                         fuse_ptr;
  logic [TAG_W-1:0]             lk_tag, fill_tag, inv_tag;
  tlb_ent_t                     sel;

  assign lk_tag   = lk_va[VA_W-1:PG_W];
  assign fill_tag = fill_va[VA_W-1:PG_W];
  assign inv_tag  = inv_va[VA_W-1:PG_W];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      tag_v[i] = ent_q[i].tag;
      glb_v[i] = ent_q[i].glb;
    end
  end

  tlb_match #(.N(ENTRIES), .TW(TAG_W)) u_lk_cmp (
    .tags(tag_v), .vld(vld_q), .key(lk_tag), .hit(lk_match));
  tlb_match #(.N(ENTRIES), .TW(TAG_W)) u_fill_cmp (
    .tags(tag_v), .vld(vld_q), .key(fill_tag), .hit(fill_match));
  tlb_match #(.N(ENTRIES), .TW(TAG_W)) u_inv_cmp (
    .tags(tag_v), .vld(vld_q), .key(inv_tag), .hit(inv_match));

  tlb_victim #(.N(ENTRIES)) u_victim (
    .vld(vld_q), .same_tag(fill_match), .ptr(ptr_q),
    .idx(fidx), .use_ptr(fuse_ptr));

  // Lookup read: one-hot select from the entry array
  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) sel = ent_q[i];
  end

  assign lk_hit   = |lk_match;
  assign walk_req = lk_valid && !lk_hit;
  assign lk_pa    = {sel.pfn, lk_va[PG_W-1:0]};
  assign lk_wr    = sel.wr;
  assign lk_usr   = sel.usr;
  assign lk_nx    = sel.nx;

  // Next valid vector: fill first, then invalidate / flush on the result
  always_comb begin
    vld_n = vld_q;
    if (fill_en) vld_n[fidx] = 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      logic slot_filled;
      slot_filled = fill_en && (fidx == IW'(i));
      if (inv_en) begin
        if (slot_filled ? (fill_tag == inv_tag) : inv_match[i])
          vld_n[i] = 1'b0;
      end
      if (root_sw) begin
        if (!(slot_filled ? fill_glb : ent_q[i].glb))
          vld_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_n;
      if (fill_en && fuse_ptr)
        ptr_q <= (ptr_q == IW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // Entry payload: write-only-on-fill storage, no reset
  always_ff @(posedge clk) begin
    if (fill_en)
      ent_q[fidx] <= '{tag: fill_tag, pfn: fill_pfn, wr: fill_wr,
                       usr: fill_usr, nx: fill_nx, glb: fill_glb};
  end
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int N  = 16,
  parameter int TW = 36
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       vld_q,
  input logic [N-1:0]       glb_v,
  input logic [N-1:0][TW-1:0] tag_v,
  input logic [N-1:0]       lk_match,
  input logic               fill_en,
  input logic               inv_en,
  input logic [TW-1:0]      inv_tag,
  input logic               root_sw
);
  logic [TW-1:0] inv_tag_d;
  always_ff @(posedge clk) inv_tag_d <= inv_tag;

  function automatic logic tag_live(input logic [TW-1:0] t);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N; i++)
      if (vld_q[i] && tag_v[i] == t) r = 1'b1;
    return r;
  endfunction

  p_reset_empty_r1: assert property (@(posedge clk) rst |=> (vld_q == '0));

  p_no_dup_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  p_fill_no_loss_r5: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !inv_en && !root_sw) |=>
      (vld_q != '0) && ($countones(vld_q) >= $countones($past(vld_q))));

  p_inv_gone_r6: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> !tag_live(inv_tag_d));

  p_flush_global_r7: assert property (@(posedge clk) disable iff (rst)
    root_sw |=> ((vld_q & ~glb_v) == '0));
endmodule

bind tlb_cache tlb_cache_chk #(.N(ENTRIES), .TW(tlb_pkg::TAG_W)) u_chk (
  .clk(clk), .rst(rst), .vld_q(vld_q), .glb_v(glb_v), .tag_v(tag_v),
  .lk_match(lk_match), .fill_en(fill_en), .inv_en(inv_en),
  .inv_tag(inv_tag), .root_sw(root_sw));

// File: tb/sim_tlb_cache.sv
`timescale 1ns/1ps
module sim_tlb_cache;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [47:0] lk_va;
  logic        lk_hit, walk_req, lk_wr, lk_usr, lk_nx;
  logic [47:0] lk_pa;
  logic        fill_en, fill_wr, fill_usr, fill_nx, fill_glb;
  logic [47:0] fill_va;
  logic [35:0] fill_pfn;
  logic        inv_en, root_sw;
  logic [47:0] inv_va;

  always #5 clk = ~clk;

  tlb_cache u0 (.*);

  typedef struct {
    logic [47:0] va;
    logic        hit;
    logic [35:0] pfn;
    logic        wr, usr, nx;
    string       rq;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  function automatic logic [47:0] va_of(int k, logic [11:0] off);
    return 48'h0010_0000_0000 + (48'(k) << 12) + 48'(off);
  endfunction
  function automatic logic [35:0] pfn_of(int k);
    return 36'h0_0ABC_0000 + 36'(k);
  endfunction

  task automatic idle_ctl();
    lk_valid = 0; lk_va = '0; fill_en = 0; fill_va = '0; fill_pfn = '0;
    fill_wr = 0; fill_usr = 0; fill_nx = 0; fill_glb = 0;
    inv_en = 0; inv_va = '0; root_sw = 0;
  endtask

  task automatic look(input logic [47:0] va, input logic eh,
                      input logic [35:0] ep, input logic ew, eu, en,
                      input string rq);
    exp_t e;
    @(negedge clk);
    idle_ctl();
    lk_valid = 1; lk_va = va;
    e.va = va; e.hit = eh; e.pfn = ep; e.wr = ew; e.usr = eu; e.nx = en; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic miss(input logic [47:0] va, input string rq);
    look(va, 1'b0, '0, 1'b0, 1'b0, 1'b0, rq);
  endtask

  task automatic fill(input logic [47:0] va, input logic [35:0] p,
                      input logic w, u, n, g, input logic inv, flush);
    @(negedge clk);
    idle_ctl();
    fill_en = 1; fill_va = va; fill_pfn = p;
    fill_wr = w; fill_usr = u; fill_nx = n; fill_glb = g;
    inv_en = inv; inv_va = va; root_sw = flush;
  endtask

  task automatic inval(input logic [47:0] va);
    @(negedge clk); idle_ctl(); inv_en = 1; inv_va = va;
  endtask

  task automatic flush();
    @(negedge clk); idle_ctl(); root_sw = 1;
  endtask

  // Monitor: compares combinational lookup results mid-cycle
  always begin
    @(negedge clk);
    #3;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (!e.hit) begin
        if (lk_hit !== 1'b0 || walk_req !== 1'b1) begin
          n_bad++;
          $display("FAIL %s va=%h hit/req got %b%b exp 01", e.rq, e.va, lk_hit, walk_req);
        end
      end else if (lk_hit !== 1'b1 || walk_req !== 1'b0 ||
                   lk_pa !== {e.pfn, e.va[11:0]} ||
                   {lk_wr, lk_usr, lk_nx} !== {e.wr, e.usr, e.nx}) begin
        n_bad++;
        $display("FAIL %s va=%h got hit=%b req=%b pa=%h f=%b%b%b exp pa=%h f=%b%b%b",
                 e.rq, e.va, lk_hit, walk_req, lk_pa, lk_wr, lk_usr, lk_nx,
                 {e.pfn, e.va[11:0]}, e.wr, e.usr, e.nx);
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hung exp done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_ctl();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1, R3: empty after reset
    miss(va_of(1, 12'h000), "R1");
    miss(va_of(44, 12'h010), "R3");

    // R2, R4, R9: fill A then hit at another offset
    fill(va_of(1, 12'h000), pfn_of(1), 1, 0, 1, 0, 0, 0);
    look(va_of(1, 12'h7FF), 1, pfn_of(1), 1, 0, 1, "R2");
    look(va_of(1, 12'hFFF), 1, pfn_of(1), 1, 0, 1, "R9");

    // B global, then refill A in place (R4)
    fill(va_of(2, 12'h0), pfn_of(2), 1, 1, 0, 1, 0, 0);
    fill(va_of(1, 12'h0), 36'h777, 0, 1, 0, 0, 0, 0);
    look(va_of(1, 12'h123), 1, 36'h777, 0, 1, 0, "R4");

    for (int j = 0; j < 14; j++)
      fill(va_of(10 + j, 12'h0), pfn_of(10 + j), 1, 1, 0, 0, 0, 0);
    // all 16 distinct tags present: refill did not duplicate (R4)
    look(va_of(1, 12'h0), 1, 36'h777, 0, 1, 0, "R4");
    look(va_of(2, 12'h0), 1, pfn_of(2), 1, 1, 0, "R4");
    for (int j = 0; j < 14; j++)
      look(va_of(10 + j, 12'h456), 1, pfn_of(10 + j), 1, 1, 0, "R4");

    // R5: full -> round robin evicts slot0 (A) then slot1 (B)
    fill(va_of(40, 12'h0), pfn_of(40), 1, 1, 0, 0, 0, 0);
    miss(va_of(1, 12'h0), "R5");
    look(va_of(40, 12'h0), 1, pfn_of(40), 1, 1, 0, "R5");
    fill(va_of(41, 12'h0), pfn_of(41), 1, 1, 0, 0, 0, 0);
    miss(va_of(2, 12'h0), "R5");

    // R6: invalidate X only
    inval(va_of(40, 12'h0));
    miss(va_of(40, 12'h0), "R6");
    look(va_of(41, 12'h0), 1, pfn_of(41), 1, 1, 0, "R6");
    look(va_of(23, 12'h0), 1, pfn_of(23), 1, 1, 0, "R6");

    // R5: hole taken first, pointer untouched; next fill evicts slot2 (C0)
    fill(va_of(42, 12'h0), pfn_of(42), 1, 1, 0, 0, 0, 0);
    look(va_of(10, 12'h0), 1, pfn_of(10), 1, 1, 0, "R5");
    fill(va_of(43, 12'h0), pfn_of(43), 1, 1, 0, 0, 0, 0);
    miss(va_of(10, 12'h0), "R5");
    look(va_of(42, 12'h0), 1, pfn_of(42), 1, 1, 0, "R5");
    look(va_of(11, 12'h0), 1, pfn_of(11), 1, 1, 0, "R5");

    // R7: global G evicts slot3, then root switch
    fill(va_of(44, 12'h0), pfn_of(44), 0, 0, 1, 1, 0, 0);
    flush();
    look(va_of(44, 12'h0), 1, pfn_of(44), 0, 0, 1, "R7");
    miss(va_of(41, 12'h0), "R7");
    miss(va_of(43, 12'h0), "R7");
    miss(va_of(20, 12'h0), "R7");

    // R8: same-cycle fill with invalidate / flush
    fill(va_of(50, 12'h0), pfn_of(50), 1, 1, 0, 0, 1, 0);
    miss(va_of(50, 12'h0), "R8");
    fill(va_of(51, 12'h0), pfn_of(51), 1, 0, 0, 1, 0, 1);
    look(va_of(51, 12'h0), 1, pfn_of(51), 1, 0, 0, "R8");
    fill(va_of(52, 12'h0), pfn_of(52), 1, 0, 0, 0, 0, 1);
    miss(va_of(52, 12'h0), "R8");
    look(va_of(44, 12'h0), 1, pfn_of(44), 0, 0, 1, "R8");

    // R9: invalidate with a different page offset
    inval(va_of(51, 12'hFFF));
    miss(va_of(51, 12'h000), "R9");
    look(va_of(44, 12'h0), 1, pfn_of(44), 0, 0, 1, "R9");

    @(negedge clk); idle_ctl();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule